// File: doc/BRIEF.md
# Toggle Handshake Scan Synchronizer

This block connects an external tester to a scan chain whose shift clock is generated on chip at a varying rate. The tester cannot know when the chain will shift next. A two-phase toggle handshake lets the tester follow the on-chip pace. The tester places a scan-in bit on its data line and then flips its request level. The block brings that level change into its own clock domain and captures the bit. The captured bit then waits as a pending transfer.

When the on-chip shift strobe fires and a bit is pending, the block enables exactly one shift of the chain. At the same moment it captures the bit leaving the chain for the tester and flips its acknowledge level. The tester treats matching request and acknowledge levels as its permission to supply the next bit and read the scan-out bit. A strobe that arrives while nothing is pending stalls the chain.

Top module: `scan_tgl_sync`

## Requirements
- R1: While reset is held low at a rising edge, the following all read 0 after that edge: the acknowledge level, the shift enable, the presented scan-in bit and the tester scan-out bit. No transfer is pending after reset.
- R2: Let the request level sampled at rising edge k differ from the level sampled at edge k-1. Then the data bit sampled at edge k+2 is captured, presented on `chain_si` and marked pending. Both rising and falling request changes count.
- R3: The presented scan-in bit changes only at a capture. Changes on the tester data line while the request level is steady have no effect on `chain_si`.
- R4: `chain_shift_en` is high in exactly those cycles in which `dyn_shift_stb` is high and a captured bit is pending.
- R5: A shift strobe with no bit pending causes a stall. `chain_shift_en` stays low and the acknowledge level does not change.
- R6: The rising edge that ends a cycle with `chain_shift_en` high flips `tst_ack_tgl` once and clears the pending transfer. The acknowledge level is steady at every other edge.
- R7: At that same edge, `tst_dout` takes the value of `chain_so`. `tst_dout` is steady at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | On-chip clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tst_req_tgl | input | 1 | Tester request level; each flip offers a new bit (asynchronous) |
| tst_din | input | 1 | Tester scan-in data; stable from before the request flip until capture |
| dyn_shift_stb | input | 1 | One-cycle strobe from the dynamic scan clock generator |
| chain_so | input | 1 | Bit leaving the last flip-flop of the scan chain |
| tst_ack_tgl | output | 1 | Acknowledge level; flips when a bit has been shifted in |
| tst_dout | output | 1 | Scan-out bit held for the tester |
| chain_si | output | 1 | Captured scan-in bit driven into the chain |
| chain_shift_en | output | 1 | Shift enable for the chain for one cycle |

## Verification
The embedded assertions check the per-edge rules on every cycle. The acknowledge level flips exactly at a shift and holds otherwise. The tester scan-out register loads only at a shift. The presented bit holds unless a request edge was detected, and a detected edge always leaves a transfer pending. The bench scenarios cover the end-to-end properties. These are the two-edge synchronizer latency before capture, stalls under dense and sparse strobe patterns, tester data wiggling between transfers, and the exact order of bits delivered to the chain compared with the order sent.

// File: rtl/scan_sync_pkg.sv
// Shared definitions for the toggle handshake scan synchronizer.
// Assumes nothing beyond a single clock domain for the on-chip side.
package scan_sync_pkg;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // One captured tester bit and whether it still awaits a shift.
    typedef struct packed {
        logic bit_val;
        logic pending;
    } hold_t;
endpackage

// File: rtl/tgl_level_sync.sv
// Multi-flop synchronizer for an asynchronous toggle level.
// Assumes STAGES >= 2 and that the input level changes rarely
// compared with the clock.
module tgl_level_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_lvl,
    output logic sync_lvl
);
    logic [STAGES-1:0] stage_q;

    // Shift the level through the chain of flops, clearing on reset.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= async_lvl;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_lvl = stage_q[STAGES-1];
endmodule

// File: rtl/tgl_edge_detect.sv
// Turns a synchronized toggle level into a one-cycle pulse on any change.
// Assumes its input is already in the clk domain.
module tgl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign pulse = lvl ^ prev_q;
endmodule

// File: rtl/bit_hold.sv
// Holds one accepted tester bit until the dynamic strobe shifts it in,
// then flips the acknowledge level and latches the scan-out bit.
// Assumes the tester never offers a new bit while one is pending.
module bit_hold
    import scan_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic din,
    input  logic stb,
    input  logic so_in,
    output logic bit_q,
    output logic pend_q,
    output logic shift_en,
    output logic ack_q,
    output logic so_q
);
    hold_t hold_q;
    logic  ack_r;
    logic  so_r;

    assign shift_en = stb & hold_q.pending;
    assign bit_q    = hold_q.bit_val;
    assign pend_q   = hold_q.pending;
    assign ack_q    = ack_r;
    assign so_q     = so_r;

    // Capture on a request edge; retire the bit when a shift happens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q.bit_val <= din;
            hold_q.pending <= 1'b1;
        end else if (shift_en) begin
            hold_q.pending <= 1'b0;
        end
    end

    // Flip acknowledge and latch the outgoing chain bit on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0;
            so_r  <= 1'b0;
        end else if (shift_en) begin
            ack_r <= ~ack_r;
            so_r  <= so_in;
        end
    end

    a_r6_ack_flips_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (ack_q != $past(ack_q)));
    a_r6_ack_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ack_q));
    a_r7_dout_loads_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (so_q == $past(so_in)));
    a_r3_bit_holds_without_take: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(bit_q));
endmodule

// File: rtl/scan_tgl_sync.sv
// Top of the toggle handshake scan synchronizer: synchronizes the tester
// request level, detects its edges, and paces bits into the scan chain
// at the rate of the on-chip dynamic shift strobe.
// Assumes tst_din is stable from before a request flip until capture.
module scan_tgl_sync
    import scan_sync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tst_req_tgl,
    input  logic tst_din,
    input  logic dyn_shift_stb,
    input  logic chain_so,
    output logic tst_ack_tgl,
    output logic tst_dout,
    output logic chain_si,
    output logic chain_shift_en
);
    logic req_sync;
    logic req_edge;
    logic pending;

    tgl_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_lvl(tst_req_tgl), .sync_lvl(req_sync)
    );

    tgl_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(req_sync), .pulse(req_edge)
    );

    bit_hold u_hold (
        .clk(clk), .rst_n(rst_n), .take(req_edge), .din(tst_din),
        .stb(dyn_shift_stb), .so_in(chain_so), .bit_q(chain_si),
        .pend_q(pending), .shift_en(chain_shift_en), .ack_q(tst_ack_tgl),
        .so_q(tst_dout)
    );

    a_r2_edge_leaves_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_edge |=> pending);
    a_r5_no_ack_change_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> $stable(tst_ack_tgl));
endmodule

// File: tb/tb_scan_tgl_sync.sv
module tb_scan_tgl_sync;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, din = 1'b0, stb = 1'b0, so = 1'b0;
    logic ack, dout, si, sen;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int strobe_mode = 0;

    always #5 clk = ~clk;

    scan_tgl_sync dut (
        .clk(clk), .rst_n(rst_n), .tst_req_tgl(req), .tst_din(din),
        .dyn_shift_stb(stb), .chain_so(so), .tst_ack_tgl(ack),
        .tst_dout(dout), .chain_si(si), .chain_shift_en(sen)
    );

    // Behavioural reference: history of sampled request levels and model state.
    int hist[$];
    bit m_pend, m_bit, m_ack, m_so;
    bit sent[$];
    bit shifted[$];

    always @(posedge clk) begin
        bit cap, sh;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_pend = 0; m_bit = 0; m_ack = 0; m_so = 0;
        end else begin
            cap = (hist[$-1] != hist[$-2]);
            sh  = stb && m_pend;
            if (sh) begin
                shifted.push_back(m_bit);
                m_ack = ~m_ack; m_so = so; m_pend = 0;
            end
            if (cap) begin
                m_bit = din; m_pend = 1;
            end
            hist.push_back(int'(req));
            void'(hist.pop_front());
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Compare every cycle shortly after the rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R6 ack level", ack, m_ack);
            chk("R2/R3 chain_si", si, m_bit);
            chk("R4/R5 shift enable", sen, stb && m_pend);
            chk("R7 tst_dout", dout, m_so);
        end
    end

    // Dynamic strobe and chain output, driven on falling edges.
    always @(negedge clk) begin
        so <= 1'($urandom);
        case (strobe_mode)
            0: stb <= 1'b1;                              // every cycle
            1: stb <= (($urandom % 7) == 0);             // sparse
            default: stb <= 1'($urandom);                // irregular
        endcase
    end

    task automatic send_bit(input bit b);
        while (ack !== req) @(negedge clk);
        din <= b;
        sent.push_back(b);
        @(negedge clk);
        req <= ~req;
        repeat (4) @(negedge clk);
        while (ack !== req) begin
            din <= 1'($urandom);   // R3: wiggle data with no request change
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 ack", ack, 1'b0);
        chk("R1 shift_en", sen, 1'b0);
        chk("R1 chain_si", si, 1'b0);
        chk("R1 tst_dout", dout, 1'b0);
        rst_n <= 1'b1;
        // R5: strobes with nothing pending must stall
        repeat (10) @(negedge clk);
        chk("R5 stall ack", ack, 1'b0);
        chk("R5 stall shift_en", sen, 1'b0);
        for (int m = 0; m < 3; m++) begin
            strobe_mode = m;
            for (int i = 0; i < 20; i++) send_bit(bit'((i * 5 + m) % 3 == 0));
        end
        strobe_mode = 2;
        for (int i = 0; i < 8; i++) send_bit(1'b1);   // repeated value, both edge directions
        while (ack !== req) @(negedge clk);
        repeat (5) @(negedge clk);
        // R2/R6: every sent bit reached the chain exactly once, in order
        checks++;
        if (sent.size() != shifted.size()) begin
            failures++;
            $display("FAIL R6 shift count: actual=%0d expected=%0d", shifted.size(), sent.size());
        end
        for (int i = 0; i < sent.size() && i < shifted.size(); i++)
            chk("R2 bit order", shifted[i], sent[i]);
        done = 1;
        summary();
    end

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end
endmodule